// File: doc/BRIEF.md
# Modem Control and Interrupt Gating

This block holds the per-channel modem control register of a serial port and watches the four modem status lines. Two bits of the control register drive the active-low data-terminal-ready and request-to-send outputs. A third bit enables the three-state driver of the channel interrupt. The top bit selects a divide-by-4 clock prescaler. The value of that top bit is taken from a strap pin while reset is held.

The clear-to-send, data-set-ready, ring and carrier-detect inputs are active low and asynchronous. Each one passes through a two-flop synchronizer, and its level appears in the upper half of a status byte. A change on a line sets a sticky change flag in the lower half of that byte. The ring line is the exception: its flag sets only on a low-to-high transition of the pin, which is the end of a ring. A read strobe on the status byte clears every change flag. The channel interrupt is raised when the modem-status interrupt is enabled and any change flag is set.

The CPU side is reduced to a write strobe with write data for the control register and a read strobe for the status byte. Both registers are always visible on output buses.

Top module: `mdm_ctrl`

## Requirements
- R1: In the first cycle after reset is released, control bits 6..0 are 0, `dtr_n_o` and `rts_n_o` are 1, all change flags are 0, and `irq_oe_o` is 0 when `irq_force_i` is low.
- R2: One cycle after a control write, `dtr_n_o` equals the inverse of written bit 0 and `rts_n_o` equals the inverse of written bit 1.
- R3: While reset is held low, control bit 7 takes the inverse of `clk_sel_i` (pin 1 gives 0, divide-by-1; pin 0 gives 1, divide-by-4), and `presc_div4_o` follows bit 7. After reset is released, changes on `clk_sel_i` have no effect.
- R4: A control write stores all 8 bits one cycle later, bit 7 included, and `ctl_q_o` shows the stored value.
- R5: `irq_oe_o` is 1 whenever `irq_force_i` is 1. Otherwise it equals control bit 3.
- R6: Status bits 4, 5, 6, 7 show the active-high asserted level of clear-to-send, data-set-ready, ring and carrier-detect. Each reflects a pin level two cycles after that level was sampled.
- R7: Status bits 0, 1 and 3 (clear-to-send, data-set-ready, carrier-detect changes) set three cycles after any change of the matching pin.
- R8: Status bit 2 sets only when the ring pin goes from low to high. A high-to-low transition leaves it unchanged.
- R9: A change flag falls only at the clock edge that follows a read strobe. A change detected in the same cycle as the read keeps its flag set.
- R10: `irq_o` is 1 exactly when `msi_en_i` is 1 and at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_sel_i | input | 1 | Prescaler strap, sampled while in reset |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| msr_rd_i | input | 1 | Status read strobe, clears change flags |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| irq_force_i | input | 1 | Forces the interrupt driver on (board ties it low by default) |
| cts_n_i | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator, active low, asynchronous |
| cd_n_i | input | 1 | Carrier detect, active low, asynchronous |
| ctl_q_o | output | 8 | Control register contents |
| msr_q_o | output | 8 | Status byte: [7:4] levels, [3:0] change flags |
| dtr_n_o | output | 1 | Data-terminal-ready, active low |
| rts_n_o | output | 1 | Request-to-send, active low |
| presc_div4_o | output | 1 | 1 selects the divide-by-4 prescaler |
| irq_o | output | 1 | Interrupt level, active high |
| irq_oe_o | output | 1 | Interrupt driver enable; 0 means high impedance |

## Verification
A change flag that is set wrongly or stuck shows on `irq_o` in the same cycle if the interrupt is enabled. A missed edge shows three cycles after the pin moves, when the expected flag fails to appear. A corrupt control register appears on the modem outputs and the driver enable one cycle after the write or the reset release. A wrong strap capture appears on the prescaler output in the first cycle after release. The reference model follows every line on every clock, so any such error is reported within a few cycles of its cause.

// File: rtl/mdm_pkg.sv
// Package: shared widths and bit positions for the modem control block.
// Assumes a single channel; replicate the top per channel.
package mdm_pkg;
    localparam int CTL_W     = 8;
    localparam int MDM_W     = 4;
    // control register bit positions
    localparam int CTL_DTR   = 0;
    localparam int CTL_RTS   = 1;
    localparam int CTL_IRQEN = 3;
    localparam int CTL_PRESC = 7;
    // modem line index, also change-flag bit position in the status byte
    localparam int M_CTS = 0;
    localparam int M_DSR = 1;
    localparam int M_RI  = 2;
    localparam int M_CD  = 3;
    // lines whose flag sets only on a rising pin (end of ring)
    localparam logic [MDM_W-1:0] RISE_ONLY = MDM_W'(1) << M_RI;
endpackage

// File: rtl/mdm_sync.sv
// Module: multi-stage synchronizer for asynchronous inputs.
// Assumes inputs are quasi-static between transitions; each bit is
// synchronized on its own, with no cross-bit coherency.
module mdm_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first stage captures the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
// Module: change detector with sticky flags and clear-on-read.
// Assumes a synchronized active-low input. Bits set in RISE_MASK flag
// only a low-to-high input edge. A new event wins over a clear.
module mdm_delta #(
    parameter int         W         = 4,
    parameter logic [W-1:0] RISE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_n,
    input  logic         clr,
    output logic [W-1:0] flag
);
    logic [W-1:0] prev_n;
    logic [W-1:0] ev;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_ev
            if (RISE_MASK[i]) begin : g_rise
                assign ev[i] = ~prev_n[i] & lvl_n[i];
            end else begin : g_any
                assign ev[i] = prev_n[i] ^ lvl_n[i];
            end
        end
    endgenerate

    // hold the previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= '1;
        else        prev_n <= lvl_n;
    end

    // sticky flags: clear on read, set on event, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else        flag <= (flag & ~{W{clr}}) | ev;
    end
endmodule

// File: rtl/mdm_ctl_reg.sv
// Module: modem control register with strap capture of the prescaler bit.
// Assumes synchronous reset. While reset is low the prescaler bit keeps
// loading the inverted strap, so the value at release is the one kept.
module mdm_ctl_reg
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] q
);
    // reset loads the inverted strap into the prescaler bit, writes load all
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q            <= '0;
            q[CTL_PRESC] <= ~strap;
        end else if (wr) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/mdm_ctrl.sv
// Module: top of the per-channel modem control and interrupt gating block.
// Assumes one clock domain for the CPU side; modem pins are asynchronous.
// The interrupt pad driver is modelled as a value plus an output enable.
module mdm_ctrl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_sel_i,
    input  logic       ctl_wr_i,
    input  logic [7:0] ctl_wdata_i,
    input  logic       msr_rd_i,
    input  logic       msi_en_i,
    input  logic       irq_force_i,
    input  logic       cts_n_i,
    input  logic       dsr_n_i,
    input  logic       ri_n_i,
    input  logic       cd_n_i,
    output logic [7:0] ctl_q_o,
    output logic [7:0] msr_q_o,
    output logic       dtr_n_o,
    output logic       rts_n_o,
    output logic       presc_div4_o,
    output logic       irq_o,
    output logic       irq_oe_o
);
    logic [MDM_W-1:0] pins_n;
    logic [MDM_W-1:0] sync_n;
    logic [MDM_W-1:0] chg;
    logic [CTL_W-1:0] ctl;

    assign pins_n[M_CTS] = cts_n_i;
    assign pins_n[M_DSR] = dsr_n_i;
    assign pins_n[M_RI]  = ri_n_i;
    assign pins_n[M_CD]  = cd_n_i;

    mdm_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .strap (clk_sel_i),
        .wr    (ctl_wr_i),
        .wdata (ctl_wdata_i),
        .q     (ctl)
    );

    mdm_sync #(.W(MDM_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_n),
        .q     (sync_n)
    );

    mdm_delta #(.W(MDM_W), .RISE_MASK(RISE_ONLY)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_n (sync_n),
        .clr   (msr_rd_i),
        .flag  (chg)
    );

    // drive outputs from register state and gating inputs
    always_comb begin
        ctl_q_o      = ctl;
        msr_q_o      = {~sync_n, chg};
        dtr_n_o      = ~ctl[CTL_DTR];
        rts_n_o      = ~ctl[CTL_RTS];
        presc_div4_o = ctl[CTL_PRESC];
        irq_o        = msi_en_i & (|chg);
        irq_oe_o     = irq_force_i | ctl[CTL_IRQEN];
    end
endmodule

// File: rtl/mdm_ctrl_chk.sv
// Module: temporal checks on the modem control block, bound to the top.
module mdm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_sel_i,
    input logic       ctl_wr_i,
    input logic [7:0] ctl_wdata_i,
    input logic       msr_rd_i,
    input logic       irq_force_i,
    input logic [7:0] ctl_q_o,
    input logic [7:0] msr_q_o,
    input logic       dtr_n_o,
    input logic       rts_n_o,
    input logic       irq_oe_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dtr_n_o && rts_n_o && ctl_q_o[6:0] == 7'd0 && msr_q_o[3:0] == 4'd0));

    // R3
    strap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ctl_q_o[7] == ~$past(clk_sel_i)));

    // R4
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> (ctl_q_o == $past(ctl_wdata_i)));

    // R2
    dtr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> (dtr_n_o == ~$past(ctl_wdata_i[0]) && rts_n_o == ~$past(ctl_wdata_i[1])));

    // R5
    irq_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_force_i |-> irq_oe_o);

    // R5
    irq_enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_i && ctl_wdata_i[3]) |=> irq_oe_o);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|($past(msr_q_o[3:0]) & ~msr_q_o[3:0]))) |-> $past(msr_rd_i));
endmodule

bind mdm_ctrl mdm_ctrl_chk u_mdm_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_sel_i   (clk_sel_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (ctl_wdata_i),
    .msr_rd_i    (msr_rd_i),
    .irq_force_i (irq_force_i),
    .ctl_q_o     (ctl_q_o),
    .msr_q_o     (msr_q_o),
    .dtr_n_o     (dtr_n_o),
    .rts_n_o     (rts_n_o),
    .irq_oe_o    (irq_oe_o)
);

// File: tb/mdm_ctrl_bench.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks on reset, strap capture, ring edges and clear-on-read.
module mdm_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       clk_sel_i;
    logic       ctl_wr_i;
    logic [7:0] ctl_wdata_i;
    logic       msr_rd_i;
    logic       msi_en_i;
    logic       irq_force_i;
    logic       cts_n_i, dsr_n_i, ri_n_i, cd_n_i;
    logic [7:0] ctl_q_o, msr_q_o;
    logic       dtr_n_o, rts_n_o, presc_div4_o, irq_o, irq_oe_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mdm_ctrl u_mdm_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_sel_i(clk_sel_i),
        .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .msr_rd_i(msr_rd_i),
        .msi_en_i(msi_en_i), .irq_force_i(irq_force_i),
        .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i), .ri_n_i(ri_n_i), .cd_n_i(cd_n_i),
        .ctl_q_o(ctl_q_o), .msr_q_o(msr_q_o), .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o),
        .presc_div4_o(presc_div4_o), .irq_o(irq_o), .irq_oe_o(irq_oe_o)
    );

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model: history of pin samples, control byte, change flags
    logic [3:0] hist[$];
    logic [7:0] m_ctl;
    logic [3:0] m_flag;

    always @(posedge clk) begin
        logic [3:0] ev;
        if (!rst_n) begin
            m_ctl  = {~clk_sel_i, 7'd0};
            m_flag = 4'd0;
            hist   = {4'hF, 4'hF, 4'hF};
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (i == 2) ev[i] = (hist[2][i] == 1'b0) && (hist[1][i] == 1'b1);
                else        ev[i] = hist[2][i] != hist[1][i];
            end
            m_flag = (msr_rd_i ? 4'd0 : m_flag) | ev;
            if (ctl_wr_i) m_ctl = ctl_wdata_i;
            hist.push_front({cd_n_i, ri_n_i, dsr_n_i, cts_n_i});
            void'(hist.pop_back());
        end
        cmp_on = 1'b1;
    end

    // compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R4", "ctl_q", ctl_q_o, m_ctl);
            chk("R2", "dtr_n", {7'd0, dtr_n_o}, {7'd0, ~m_ctl[0]});
            chk("R2", "rts_n", {7'd0, rts_n_o}, {7'd0, ~m_ctl[1]});
            chk("R3", "presc", {7'd0, presc_div4_o}, {7'd0, m_ctl[7]});
            chk("R5", "irq_oe", {7'd0, irq_oe_o}, {7'd0, irq_force_i | m_ctl[3]});
            chk("R6", "levels", {4'd0, msr_q_o[7:4]}, {4'd0, ~hist[1]});
            chk("R7", "flags", {4'd0, msr_q_o[3:0]}, {4'd0, m_flag});
            chk("R10", "irq", {7'd0, irq_o}, {7'd0, msi_en_i & (|m_flag)});
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; clk_sel_i = 1'b1; ctl_wr_i = 1'b0; ctl_wdata_i = 8'h00;
        msr_rd_i = 1'b0; msi_en_i = 1'b0; irq_force_i = 1'b0;
        cts_n_i = 1'b1; dsr_n_i = 1'b1; ri_n_i = 1'b1; cd_n_i = 1'b1;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state; R3 strap high gives divide-by-1
        chk("R1", "ctl after reset", ctl_q_o, 8'h00);
        chk("R1", "dtr/rts after reset", {6'd0, dtr_n_o, rts_n_o}, 8'h03);
        chk("R1", "irq_oe after reset", {7'd0, irq_oe_o}, 8'h00);
        chk("R3", "presc strap high", {7'd0, presc_div4_o}, 8'h00);
        step();
        clk_sel_i = 1'b0;
        ctl_wr_i = 1'b1; ctl_wdata_i = 8'h03; step(); ctl_wr_i = 1'b0;
        @(negedge clk);
        chk("R2", "dtr/rts asserted", {6'd0, dtr_n_o, rts_n_o}, 8'h00);
        chk("R3", "strap ignored after release", {7'd0, presc_div4_o}, 8'h00);
        step();
        ctl_wr_i = 1'b1; ctl_wdata_i = 8'h88; step(); ctl_wr_i = 1'b0;
        @(negedge clk);
        chk("R4", "bit 7 writable", {7'd0, presc_div4_o}, 8'h01);
        chk("R5", "bit 3 enables driver", {7'd0, irq_oe_o}, 8'h01);
        step();
        ctl_wr_i = 1'b1; ctl_wdata_i = 8'h00; step(); ctl_wr_i = 1'b0;
        irq_force_i = 1'b1;
        @(negedge clk);
        chk("R5", "force enables driver", {7'd0, irq_oe_o}, 8'h01);
        step(); irq_force_i = 1'b0;
        // clear-to-send change, then read
        msi_en_i = 1'b1; cts_n_i = 1'b0;
        step(3);
        @(negedge clk);
        chk("R7", "cts change flag", {7'd0, msr_q_o[0]}, 8'h01);
        chk("R6", "cts level", {7'd0, msr_q_o[4]}, 8'h01);
        chk("R10", "irq raised", {7'd0, irq_o}, 8'h01);
        step();
        msr_rd_i = 1'b1; step(); msr_rd_i = 1'b0;
        @(negedge clk);
        chk("R9", "flags cleared by read", {4'd0, msr_q_o[3:0]}, 8'h00);
        chk("R10", "irq dropped", {7'd0, irq_o}, 8'h00);
        // ring start must not flag; ring end must
        ri_n_i = 1'b0; step(5);
        @(negedge clk);
        chk("R8", "ring start no flag", {7'd0, msr_q_o[2]}, 8'h00);
        chk("R6", "ring level", {7'd0, msr_q_o[6]}, 8'h01);
        step();
        ri_n_i = 1'b1; step(5);
        @(negedge clk);
        chk("R8", "ring end flag", {7'd0, msr_q_o[2]}, 8'h01);
        step();
        // read in the same cycle the carrier event is detected
        cd_n_i = 1'b0; step(2);
        msr_rd_i = 1'b1; step(); msr_rd_i = 1'b0;
        @(negedge clk);
        chk("R9", "event beats clear", {4'd0, msr_q_o[3:0]}, 8'h08);
        step();
        // second reset with strap low: divide-by-4
        rst_n = 1'b0; step(2); rst_n = 1'b1;
        @(negedge clk);
        chk("R3", "presc strap low", {7'd0, presc_div4_o}, 8'h01);
        step(); clk_sel_i = 1'b1; step(3);
        @(negedge clk);
        chk("R3", "strap change ignored", {7'd0, ctl_q_o[7]}, 8'h01);
        step();
        // mixed stimulus, checked by the per-cycle model compare
        for (int k = 0; k < 4000; k++) begin
            ctl_wr_i    = ($urandom_range(0, 7) == 0);
            ctl_wdata_i = 8'($urandom);
            msr_rd_i    = ($urandom_range(0, 5) == 0);
            msi_en_i    = ($urandom_range(0, 3) != 0);
            irq_force_i = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 3) == 0) begin
                {cd_n_i, ri_n_i, dsr_n_i, cts_n_i} = 4'($urandom);
            end
            clk_sel_i   = 1'($urandom);
            rst_n       = ($urandom_range(0, 499) != 0);
            step();
        end
        rst_n = 1'b1; ctl_wr_i = 1'b0; msr_rd_i = 1'b0;
        step(4);
        @(negedge clk);
        finish_run();
    end
endmodule